// File: doc/BRIEF.md
# Interrupt Control Register Unit

This unit is the interrupt and exception control logic of a small soft processor core. It holds four control registers: a mode word, a saved copy of the mode word, a per-line enable mask and a read-only pending view. It watches a bank of level-sensitive interrupt request lines, all of equal rank. When the pipeline signals an instruction boundary, global interrupts are on and at least one enabled line is active, the unit takes the interrupt. In that cycle it saves the mode word, drops into supervisor mode with interrupts masked, hands the pipeline the return address (current pc plus one instruction) to write into general register 29, and redirects fetch to one fixed handler address. All sources share that handler. Software finds the source by reading the pending register.

The pipeline also sends control-register reads and writes and exception-return requests through this unit. Each of these is legal only in supervisor mode. A return copies the saved mode word back and redirects fetch to the return address supplied from register 29. The unit checks privilege, drops illegal accesses and flags them, and resolves collisions between these events within the cycle. All outputs are combinational from the current state and inputs. Register updates take effect on the next rising clock edge.

Top module: `irq_ctl_unit`

## Requirements
- R1: After reset the mode word, saved mode word and enable mask are all zero. Reads of indices 0, 1 and 3 return 0, and no interrupt is taken even with every request line active.
- R2: A supervisor read of index 4 returns the bitwise AND of the request lines and the enable mask, zero-extended to the data width.
- R3: `take` is 1 exactly when `boundary` is 1, mode bit 0 (global enable) is 1, the pending set is nonzero and `ret_req` is 0. In that cycle `redirect` is 1 and `next_pc` equals the handler address (default 0x20).
- R4: On a taken interrupt the saved mode word (index 1) receives the mode word, and the mode word becomes 0. Interrupts are masked and supervisor mode is entered, so a following boundary with lines still pending is not taken.
- R5: On a taken interrupt, `ret_wr_en` is 1 and `ret_wr_data` equals `cur_pc` plus 4.
- R6: A supervisor `ret_req` restores the mode word from the saved mode word and drives `redirect` with `next_pc` equal to `ret_addr`.
- R7: When mode bit 1 (user) is 1, any control read, control write or `ret_req` raises `priv_fault`. It changes no register, reads back 0 and causes no redirect.
- R8: Supervisor writes to indices 0 (low two bits), 1 (low two bits) and 3 (low lines) update those registers. Writes to index 4 or to any other index change nothing. Reads of any index other than 0, 1, 3 and 4 return 0.
- R9: When an interrupt is taken in the same cycle as a control read or write, the interrupt wins. The write is discarded, the read returns 0, and no fault is raised.
- R10: When `ret_req` coincides with a boundary at which interrupts would otherwise be taken, the return is performed and no interrupt is taken in that cycle.
- R11: When no redirect occurs, `next_pc` is 0 and `ret_wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt request lines |
| boundary | input | 1 | Pipeline is at an instruction boundary |
| cur_pc | input | AW | Address of the instruction at the boundary |
| ret_req | input | 1 | Exception-return request |
| ret_addr | input | AW | Current value of general register 29 |
| csr_rd | input | 1 | Control-register read request |
| csr_wr | input | 1 | Control-register write request |
| csr_idx | input | 5 | Control-register index |
| csr_wdata | input | DW | Control-register write data |
| csr_rdata | output | DW | Control-register read data |
| priv_fault | output | 1 | Privileged access attempted in user mode |
| take | output | 1 | Interrupt taken this cycle; flush the pipeline |
| redirect | output | 1 | Fetch must restart at `next_pc` |
| next_pc | output | AW | Redirect target |
| ret_wr_en | output | 1 | Write `ret_wr_data` into general register 29 |
| ret_wr_data | output | AW | Return address to save |

## Verification
The collisions that matter are a taken interrupt landing in the same cycle as a control write or read, and an exception return landing on a boundary where an enabled line is pending. Directed steps raise a pending line at a boundary together with a write to the mask register, and then together with a return request. Mode and mask are read back afterwards to confirm that the interrupt suppressed the write and that the return suppressed the interrupt. A long stretch of random stimulus then mixes all of these with user-mode entry. Every output is compared each cycle against a behavioural model written directly from the requirements.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

   localparam int IDX_W = 5;

   localparam logic [IDX_W-1:0] IDX_MODE  = 5'd0;
   localparam logic [IDX_W-1:0] IDX_SAVED = 5'd1;
   localparam logic [IDX_W-1:0] IDX_MASK  = 5'd3;
   localparam logic [IDX_W-1:0] IDX_PEND  = 5'd4;

   localparam int MODE_W = 2;

   // bit 1: user mode flag, bit 0: global interrupt enable
   typedef struct packed {
      logic user;
      logic gie;
   } mode_t;

endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
   parameter int NUM_LINES = 32
) (
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic [NUM_LINES-1:0] mask,
   output logic [NUM_LINES-1:0] pend,
   output logic                 any_pend
);

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      assign pend[g] = irq_lines[g] & mask[g];
   end

   assign any_pend = |pend;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter (
   input  logic clk,
   input  logic rst_n,
   input  logic boundary,
   input  logic gie,
   input  logic user,
   input  logic any_pend,
   input  logic ret_req,
   input  logic csr_rd,
   input  logic csr_wr,
   output logic take,
   output logic ret_go,
   output logic wr_go,
   output logic rd_go,
   output logic fault
);

   logic priv_ok;

   assign priv_ok = ~user;
   // a return request outranks an interrupt at the same boundary
   assign take    = boundary & gie & any_pend & ~ret_req;
   assign ret_go  = ret_req & priv_ok;
   // the interrupt flushes the access that shares its cycle
   assign wr_go   = csr_wr & priv_ok & ~take & ~ret_req;
   assign rd_go   = csr_rd & priv_ok & ~take;
   assign fault   = (csr_rd | csr_wr | ret_req) & user & ~take;

   p_take_needs_enable_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (gie && boundary && any_pend));

   p_ret_blocks_take_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      ret_req |-> !take);

   p_user_no_effect_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      user |-> (!wr_go && !ret_go && !rd_go));

   p_one_event_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({take, ret_go, wr_go}));

endmodule

// File: rtl/irq_csr_file.sv
module irq_csr_file
   import irq_ctl_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int DW        = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic                 ret_go,
   input  logic                 wr_go,
   input  logic                 rd_go,
   input  logic [IDX_W-1:0]     idx,
   input  logic [DW-1:0]        wdata,
   input  logic [NUM_LINES-1:0] pend,
   output mode_t                mode_q,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [DW-1:0]        rdata
);

   localparam int PAD_W = DW - NUM_LINES;

   mode_t          saved_q;
   logic [DW-1:0]  mask_ext;
   logic [DW-1:0]  pend_ext;
   logic [DW-1:0]  mode_ext;
   logic [DW-1:0]  saved_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= '0;
         saved_q <= '0;
         mask_q  <= '0;
      end else if (take) begin
         saved_q <= mode_q;
         mode_q  <= '0;
      end else if (ret_go) begin
         mode_q  <= saved_q;
      end else if (wr_go) begin
         case (idx)
            IDX_MODE:  mode_q  <= mode_t'(wdata[MODE_W-1:0]);
            IDX_SAVED: saved_q <= mode_t'(wdata[MODE_W-1:0]);
            IDX_MASK:  mask_q  <= wdata[NUM_LINES-1:0];
            default: ;
         endcase
      end
   end

   if (PAD_W == 0) begin : g_full
      assign mask_ext = mask_q;
      assign pend_ext = pend;
   end else begin : g_pad
      assign mask_ext = {{PAD_W{1'b0}}, mask_q};
      assign pend_ext = {{PAD_W{1'b0}}, pend};
   end

   assign mode_ext  = {{(DW-MODE_W){1'b0}}, mode_q};
   assign saved_ext = {{(DW-MODE_W){1'b0}}, saved_q};

   always_comb begin
      rdata = '0;
      if (rd_go) begin
         case (idx)
            IDX_MODE:  rdata = mode_ext;
            IDX_SAVED: rdata = saved_ext;
            IDX_MASK:  rdata = mask_ext;
            IDX_PEND:  rdata = pend_ext;
            default:   rdata = '0;
         endcase
      end
   end

   p_take_masks_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (mode_q == '0 && saved_q == $past(mode_q)));

   p_ret_restores_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      ret_go |=> (mode_q == $past(saved_q)));

   p_idle_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !(take || ret_go || wr_go) |=> ($stable(mode_q) && $stable(saved_q) && $stable(mask_q)));

   p_wdata_known_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_go |-> !$isunknown(wdata));

endmodule

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit
   import irq_ctl_pkg::*;
#(
   parameter int          NUM_LINES   = 32,
   parameter int          DW          = 32,
   parameter int          AW          = 32,
   parameter logic [31:0] HANDLER     = 32'h20,
   parameter int          INSTR_BYTES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 boundary,
   input  logic [AW-1:0]        cur_pc,
   input  logic                 ret_req,
   input  logic [AW-1:0]        ret_addr,
   input  logic                 csr_rd,
   input  logic                 csr_wr,
   input  logic [4:0]           csr_idx,
   input  logic [DW-1:0]        csr_wdata,
   output logic [DW-1:0]        csr_rdata,
   output logic                 priv_fault,
   output logic                 take,
   output logic                 redirect,
   output logic [AW-1:0]        next_pc,
   output logic                 ret_wr_en,
   output logic [AW-1:0]        ret_wr_data
);

   localparam logic [AW-1:0] HANDLER_A = AW'(HANDLER);
   localparam logic [AW-1:0] STEP_A    = AW'(INSTR_BYTES);

   if (NUM_LINES < 1 || NUM_LINES > DW) begin : g_bad_lines
      $error("NUM_LINES must lie between 1 and DW");
   end
   if (DW < MODE_W) begin : g_bad_dw
      $error("DW too narrow for the mode word");
   end

   mode_t                mode_q;
   logic [NUM_LINES-1:0] mask_q;
   logic [NUM_LINES-1:0] pend;
   logic                 any_pend;
   logic                 ret_go;
   logic                 wr_go;
   logic                 rd_go;

   irq_pending #(.NUM_LINES(NUM_LINES)) u_pend (
      .irq_lines (irq_lines),
      .mask      (mask_q),
      .pend      (pend),
      .any_pend  (any_pend)
   );

   irq_arbiter u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .boundary (boundary),
      .gie      (mode_q.gie),
      .user     (mode_q.user),
      .any_pend (any_pend),
      .ret_req  (ret_req),
      .csr_rd   (csr_rd),
      .csr_wr   (csr_wr),
      .take     (take),
      .ret_go   (ret_go),
      .wr_go    (wr_go),
      .rd_go    (rd_go),
      .fault    (priv_fault)
   );

   irq_csr_file #(.NUM_LINES(NUM_LINES), .DW(DW)) u_csr (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .ret_go (ret_go),
      .wr_go  (wr_go),
      .rd_go  (rd_go),
      .idx    (csr_idx),
      .wdata  (csr_wdata),
      .pend   (pend),
      .mode_q (mode_q),
      .mask_q (mask_q),
      .rdata  (csr_rdata)
   );

   assign redirect    = take | ret_go;
   assign next_pc     = take ? HANDLER_A : (ret_go ? ret_addr : '0);
   assign ret_wr_en   = take;
   assign ret_wr_data = cur_pc + STEP_A;

   p_redirect_target_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && !take) |-> (next_pc == ret_addr));

   p_quiet_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !redirect |-> (next_pc == '0 && !ret_wr_en));

   p_take_after_take_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take);

endmodule

// File: tb/tb_irq_ctl_unit.sv
`timescale 1ns/1ps
module tb_irq_ctl_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_lines = '0;
   logic        boundary = 1'b0;
   logic [31:0] cur_pc = '0;
   logic        ret_req = 1'b0;
   logic [31:0] ret_addr = '0;
   logic        csr_rd = 1'b0;
   logic        csr_wr = 1'b0;
   logic [4:0]  csr_idx = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        priv_fault;
   logic        take;
   logic        redirect;
   logic [31:0] next_pc;
   logic        ret_wr_en;
   logic [31:0] ret_wr_data;

   int total = 0;
   int bad = 0;

   // reference state
   logic [1:0]  m_mode = '0;
   logic [1:0]  m_saved = '0;
   logic [31:0] m_mask = '0;

   always #4 clk = ~clk;

   irq_ctl_unit dut (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .boundary(boundary),
      .cur_pc(cur_pc), .ret_req(ret_req), .ret_addr(ret_addr),
      .csr_rd(csr_rd), .csr_wr(csr_wr), .csr_idx(csr_idx), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .priv_fault(priv_fault), .take(take),
      .redirect(redirect), .next_pc(next_pc), .ret_wr_en(ret_wr_en),
      .ret_wr_data(ret_wr_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // one clock: drive after the falling edge, compare, then advance the model
   task automatic cyc(input logic [31:0] lines, input logic bnd, input logic [31:0] pc,
                      input logic rr, input logic [31:0] ra, input logic rd,
                      input logic wr, input logic [4:0] idx, input logic [31:0] wd);
      logic [31:0] pend, e_rdata, e_npc;
      logic e_take, user, e_ret, e_wr, e_rd, e_fault;
      irq_lines = lines; boundary = bnd; cur_pc = pc; ret_req = rr; ret_addr = ra;
      csr_rd = rd; csr_wr = wr; csr_idx = idx; csr_wdata = wd;
      #1;
      pend    = lines & m_mask;
      user    = m_mode[1];
      e_take  = bnd && m_mode[0] && (pend != 0) && !rr;
      e_ret   = rr && !user;
      e_wr    = wr && !user && !e_take && !rr;
      e_rd    = rd && !user && !e_take;
      e_fault = (rd || wr || rr) && user && !e_take;
      e_rdata = 32'h0;
      if (e_rd) begin
         case (idx)
            5'd0: e_rdata = {30'h0, m_mode};
            5'd1: e_rdata = {30'h0, m_saved};
            5'd3: e_rdata = m_mask;
            5'd4: e_rdata = pend;
            default: e_rdata = 32'h0;
         endcase
      end
      e_npc = e_take ? 32'h20 : (e_ret ? ra : 32'h0);
      chk("R3 take", {31'h0, take}, {31'h0, e_take});
      chk("R6 redirect", {31'h0, redirect}, {31'h0, e_take || e_ret});
      chk("R11 next_pc", next_pc, e_npc);
      chk("R5 ret_wr_en", {31'h0, ret_wr_en}, {31'h0, e_take});
      if (e_take) chk("R5 ret_wr_data", ret_wr_data, pc + 32'd4);
      chk("R7 priv_fault", {31'h0, priv_fault}, {31'h0, e_fault});
      chk("R8 rdata", csr_rdata, e_rdata);
      @(posedge clk);
      if (!rst_n) begin
         m_mode = '0; m_saved = '0; m_mask = '0;
      end else if (e_take) begin
         m_saved = m_mode; m_mode = 2'b00;
      end else if (e_ret) begin
         m_mode = m_saved;
      end else if (e_wr) begin
         case (idx)
            5'd0: m_mode = wd[1:0];
            5'd1: m_saved = wd[1:0];
            5'd3: m_mask = wd;
            default: ;
         endcase
      end
      @(negedge clk);
   endtask

   task automatic rd_reg(input logic [4:0] idx, input logic [31:0] lines);
      cyc(lines, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, idx, 32'h0);
   endtask

   task automatic wr_reg(input logic [4:0] idx, input logic [31:0] wd);
      cyc(32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1, idx, wd);
   endtask

   task automatic expect_read(input string tag, input logic [4:0] idx,
                              input logic [31:0] lines, input logic [31:0] exp);
      irq_lines = lines; boundary = 0; ret_req = 0; csr_rd = 1; csr_wr = 0; csr_idx = idx;
      #1;
      chk(tag, csr_rdata, exp);
      rd_reg(idx, lines);
   endtask

   initial begin
      #(200000 * 8);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      repeat (3) cyc('1, 1'b1, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0);
      rst_n = 1'b1;
      // R1: reset state
      expect_read("R1 mode", 5'd0, 32'h0, 32'h0);
      expect_read("R1 saved", 5'd1, 32'h0, 32'h0);
      expect_read("R1 mask", 5'd3, 32'h0, 32'h0);
      cyc('1, 1'b1, 32'h100, 1'b0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0);
      // R2 / R8: mask and pending view
      wr_reg(5'd3, 32'h0000_00F0);
      expect_read("R2 pend", 5'd4, 32'h0000_0130, 32'h0000_0030);
      wr_reg(5'd4, 32'hFFFF_FFFF);
      expect_read("R8 pend ro", 5'd4, 32'h0000_0130, 32'h0000_0030);
      wr_reg(5'd2, 32'h1234_5678);
      expect_read("R8 unimpl", 5'd2, 32'h0, 32'h0);
      expect_read("R8 mask kept", 5'd3, 32'h0, 32'h0000_00F0);
      // R3 / R4 / R5: take and masking
      wr_reg(5'd0, 32'h1);
      cyc(32'h10, 1'b1, 32'h1000, 1'b0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0);
      cyc(32'h10, 1'b1, 32'h1004, 1'b0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0);
      expect_read("R4 mode cleared", 5'd0, 32'h10, 32'h0);
      expect_read("R4 saved copy", 5'd1, 32'h10, 32'h1);
      // R6: return restores
      cyc(32'h0, 1'b1, 32'h40, 1'b1, 32'h1004, 1'b0, 1'b0, 5'd0, 32'h0);
      expect_read("R6 mode restored", 5'd0, 32'h0, 32'h1);
      // R10: return beats a pending interrupt
      cyc(32'h0, 1'b1, 32'h2000, 1'b1, 32'h3000, 1'b0, 1'b0, 5'd0, 32'h0);
      cyc(32'h20, 1'b1, 32'h2000, 1'b1, 32'h3000, 1'b0, 1'b0, 5'd0, 32'h0);
      expect_read("R10 mode after ret", 5'd0, 32'h0, 32'h1);
      // R9: take beats a mask write
      cyc(32'h20, 1'b1, 32'h2200, 1'b0, 32'h0, 1'b0, 1'b1, 5'd3, 32'h0);
      expect_read("R9 mask unchanged", 5'd3, 32'h0, 32'h0000_00F0);
      cyc(32'h0, 1'b0, 32'h0, 1'b1, 32'h2204, 1'b0, 1'b0, 5'd0, 32'h0);
      // R7: user mode accesses fault and change nothing
      wr_reg(5'd0, 32'h3);
      wr_reg(5'd3, 32'h0);
      rd_reg(5'd3, 32'h0);
      cyc(32'h0, 1'b0, 32'h0, 1'b1, 32'h5000, 1'b0, 1'b0, 5'd0, 32'h0);
      cyc(32'h80, 1'b1, 32'h3000, 1'b0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0);
      expect_read("R7 mask untouched", 5'd3, 32'h0, 32'h0000_00F0);
      expect_read("R7 saved user", 5'd1, 32'h0, 32'h3);
      // mixed random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] ln;
         logic [4:0]  ix;
         ln = ($urandom % 4 == 0) ? $urandom : 32'h0;
         ix = 5'($urandom % 8);
         cyc(ln, 1'($urandom % 2), $urandom & 32'hFFFF_FFFC,
             ($urandom % 10 == 0), $urandom, ($urandom % 3 == 0),
             ($urandom % 4 == 0), ix, $urandom);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule